// File: doc/BRIEF.md
# Predicated Contiguous Vector Store Unit

This block stores a vector register of 32-bit lanes to memory under a per-lane predicate. A start pulse captures the vector, the predicate, a base byte address, a scalar element index and an allowed address window. The first lane's address is the base plus four times the index, and each following lane sits one word higher. The lanes then leave through a word-wide valid/ready write port, one lane per accepted beat, lowest lane first.

Lanes whose predicate bit is clear are dropped altogether. They take no cycle, issue no beat, leave their memory word untouched, and are left out of the permission check. Before any beat goes out, the block checks every active lane address against the window. If even one active lane falls outside it, the block reports a fault with the lowest offending lane number and writes nothing. The vector width is a parameter from 128 to 2048 bits, which gives 4 to 64 lanes.

Top module: `vst_unit`

## Requirements
- R1: Lane k is written to byte address base + 4*index + 4*k, and its beat carries bits [32k+31:32k] of the captured vector.
- R2: The predicate has one bit per vector byte. Lane k is active when predicate bit 4k is 1. Bits 4k+1, 4k+2 and 4k+3 have no effect on which lanes are written.
- R3: Active lanes go out in ascending lane order, one per beat accepted with valid and ready both high. Address and data stay stable while valid waits for ready. Inactive lanes produce no beat.
- R4: The memory word of an inactive lane keeps its previous value after the store.
- R5: An inactive lane whose address lies outside the window never causes a fault.
- R6: A lane address is legal when win_lo <= address < win_hi. If any active lane is illegal, fault is 1 at done, fault_lane holds the lowest such lane, and no beat is issued.
- R7: busy is 1 from the cycle after an accepted start through the done cycle. done is a single-cycle pulse that comes one cycle after the last accepted beat, or two cycles after start when no beat is issued.
- R8: When no lane is active, the block pulses done with no beats and no fault.
- R9: A start pulse while busy is 1 is ignored, and the store in progress continues unchanged.
- R10: During and right after reset, busy, done, wr_valid and fault are 0.
- R11: fault and fault_lane keep their value after done until the next accepted start, which clears fault in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a store (accepted only when idle) |
| vec_i | input | VLEN | Vector data, lane k in bits [32k+31:32k] |
| pred_i | input | VLEN/8 | Byte predicate; bit 4k enables lane k |
| base_i | input | 32 | Base byte address |
| index_i | input | 32 | Element index, scaled by 4 |
| win_lo_i | input | 32 | Lowest legal byte address |
| win_hi_i | input | 32 | First illegal byte address above the window |
| busy_o | output | 1 | Store in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Store was refused because of an illegal active lane |
| fault_lane_o | output | log2(VLEN/32) | Lowest illegal active lane |
| wr_valid_o | output | 1 | Write beat valid |
| wr_ready_i | input | 1 | Memory accepts the beat |
| wr_addr_o | output | 32 | Beat byte address |
| wr_data_o | output | 32 | Beat data word |

## Verification
The window check and the predicate decode act on the same lanes in the same check cycle. The risk is that a lane being both inactive and out of the window gets treated the wrong way. The bench provokes this with stores that straddle a window edge, with only inactive lanes beyond the edge, and then repeats those stores with one extra lane enabled across the edge. It also sets the ignored predicate bits on several stores. Each case is judged by the fault flag and lane, the exact sequence of beats, and a word-by-word comparison of the modelled memory against a reference loop over the lanes.

// File: rtl/vst_pkg.sv
package vst_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  parameter int unsigned VST_AW = 32;
  parameter int unsigned VST_EW = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } vst_state_e;

  // byte address of one lane: base + 4*index + 4*lane
  function automatic logic [VST_AW-1:0] lane_addr(
    input logic [VST_AW-1:0] base,
    input logic [VST_AW-1:0] idx,
    input int unsigned       lane
  );
    logic [VST_AW-1:0] start;
    start = base + (idx << 2);
    return start + VST_AW'(lane << 2);
  endfunction

  // window membership, upper bound exclusive
  function automatic logic addr_ok(
    input logic [VST_AW-1:0] a,
    input logic [VST_AW-1:0] lo,
    input logic [VST_AW-1:0] hi
  );
    return (a >= lo) && (a < hi);
  endfunction
endpackage

// File: rtl/vst_pred_decode.sv
module vst_pred_decode #(
  parameter int unsigned LANES = 16,
  localparam int unsigned PW = LANES * 4
) (
  input  logic [PW-1:0]    pred_i,
  output logic [LANES-1:0] active_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [LANES-1:0] unused_hi_bits;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign active_o[k]       = pred_i[4*k];
    assign unused_hi_bits[k] = ^pred_i[4*k+1 +: 3];
  end
endmodule

// File: rtl/vst_fault_scan.sv
module vst_fault_scan #(
  parameter int unsigned LANES = 16,
  localparam int unsigned LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0]           active_i,
  input  logic [vst_pkg::VST_AW-1:0] base_i,
  input  logic [vst_pkg::VST_AW-1:0] idx_i,
  input  logic [vst_pkg::VST_AW-1:0] lo_i,
  input  logic [vst_pkg::VST_AW-1:0] hi_i,
  output logic                       any_fault_o,
  output logic [LIDX_W-1:0]          first_lane_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [LANES-1:0] bad;

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    assign bad[k] = active_i[k] &&
                    !vst_pkg::addr_ok(vst_pkg::lane_addr(base_i, idx_i, k), lo_i, hi_i);
  end

  assign any_fault_o = |bad;

  always_comb begin
    first_lane_o = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (bad[k]) first_lane_o = LIDX_W'(k);
    end
  end
endmodule

// File: rtl/vst_beat_picker.sv
module vst_beat_picker #(
  parameter int unsigned LANES = 16,
  localparam int unsigned LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0]  remain_i,
  output logic              has_next_o,
  output logic              is_last_o,
  output logic [LIDX_W-1:0] next_lane_o
);
  timeunit 1ns;
  timeprecision 1ps;

  assign has_next_o = |remain_i;
  assign is_last_o  = ($countones(remain_i) == 1);

  always_comb begin
    next_lane_o = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (remain_i[k]) next_lane_o = LIDX_W'(k);
    end
  end
endmodule

// File: rtl/vst_unit.sv
module vst_unit #(
  parameter int unsigned VLEN = 512,
  localparam int unsigned EW     = vst_pkg::VST_EW,
  localparam int unsigned AW     = vst_pkg::VST_AW,
  localparam int unsigned LANES  = VLEN / EW,
  localparam int unsigned PW     = VLEN / 8,
  localparam int unsigned LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [VLEN-1:0]   vec_i,
  input  logic [PW-1:0]     pred_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     index_i,
  input  logic [AW-1:0]     win_lo_i,
  input  logic [AW-1:0]     win_hi_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [LIDX_W-1:0] fault_lane_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [AW-1:0]     wr_addr_o,
  output logic [EW-1:0]     wr_data_o
);
  timeunit 1ns;
  timeprecision 1ps;
  import vst_pkg::*;

  vst_state_e        state_q;
  logic [VLEN-1:0]   vec_q;
  logic [AW-1:0]     base_q, idx_q, lo_q, hi_q;
  logic [LANES-1:0]  active_q, remain_q;

  // named internal events
  logic [LANES-1:0]  active_dec;
  logic              start_acc;
  logic              beat_fire;
  logic              chk_fault;
  logic [LIDX_W-1:0] chk_lane;
  logic              pick_has, pick_last;
  logic [LIDX_W-1:0] cur_lane;

  vst_pred_decode #(.LANES(LANES)) u_dec (
    .pred_i   (pred_i),
    .active_o (active_dec)
  );

  vst_fault_scan #(.LANES(LANES)) u_scan (
    .active_i     (active_q),
    .base_i       (base_q),
    .idx_i        (idx_q),
    .lo_i         (lo_q),
    .hi_i         (hi_q),
    .any_fault_o  (chk_fault),
    .first_lane_o (chk_lane)
  );

  vst_beat_picker #(.LANES(LANES)) u_pick (
    .remain_i    (remain_q),
    .has_next_o  (pick_has),
    .is_last_o   (pick_last),
    .next_lane_o (cur_lane)
  );

  assign start_acc  = start_i && (state_q == ST_IDLE);
  assign wr_valid_o = (state_q == ST_WRITE) && pick_has;
  assign beat_fire  = wr_valid_o && wr_ready_i;
  assign wr_addr_o  = lane_addr(base_q, idx_q, 32'(cur_lane));
  assign wr_data_o  = vec_q[cur_lane*EW +: EW];
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      vec_q        <= '0;
      base_q       <= '0;
      idx_q        <= '0;
      lo_q         <= '0;
      hi_q         <= '0;
      active_q     <= '0;
      remain_q     <= '0;
      fault_o      <= 1'b0;
      fault_lane_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_acc) begin
            vec_q        <= vec_i;
            base_q       <= base_i;
            idx_q        <= index_i;
            lo_q         <= win_lo_i;
            hi_q         <= win_hi_i;
            active_q     <= active_dec;
            fault_o      <= 1'b0;
            fault_lane_o <= '0;
            state_q      <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (chk_fault) begin
            fault_o      <= 1'b1;
            fault_lane_o <= chk_lane;
            state_q      <= ST_DONE;
          end else if (active_q == '0) begin
            state_q <= ST_DONE;
          end else begin
            remain_q <= active_q;
            state_q  <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (beat_fire) begin
            remain_q[cur_lane] <= 1'b0;
            if (pick_last) state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R3
  AST_WR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !pick_last |=> wr_valid_o && (wr_addr_o > $past(wr_addr_o))); // R3
  AST_WR_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> active_q[cur_lane]); // R2
  AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> addr_ok(wr_addr_o, lo_q, hi_q)); // R6
  AST_NO_WRITE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !wr_valid_o); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o); // R7
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !done_o |=> busy_o && $stable(base_q) && $stable(vec_q)); // R9
endmodule

// File: tb/vst_unit_test.sv
module vst_unit_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned VLEN  = 512;
  localparam int unsigned LANES = VLEN / 32;
  localparam int unsigned PW    = VLEN / 8;
  localparam int unsigned LW    = $clog2(LANES);
  localparam int unsigned NCASE = 8;

  // {base[15:0], idx[7:0], lane_mask[15:0], junk[0], win_lo[15:0], win_hi[15:0]}
  localparam logic [72:0] TBL [NCASE] = '{
    {16'h0100, 8'd2,  16'hFFFF, 1'b0, 16'h0000, 16'h0400},
    {16'h0040, 8'd5,  16'hA5C3, 1'b1, 16'h0000, 16'h0400},
    {16'h03E0, 8'd0,  16'h00FF, 1'b1, 16'h0000, 16'h0400},
    {16'h03E0, 8'd0,  16'h01FF, 1'b0, 16'h0000, 16'h0400},
    {16'h0200, 8'd0,  16'hFFF0, 1'b1, 16'h0210, 16'h0400},
    {16'h0200, 8'd0,  16'hFFF8, 1'b0, 16'h0210, 16'h0400},
    {16'h0080, 8'd1,  16'h0000, 1'b1, 16'h0000, 16'h0400},
    {16'h0000, 8'h30, 16'h8001, 1'b0, 16'h0000, 16'h0400}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [VLEN-1:0] vec_i = '0;
  logic [PW-1:0]   pred_i = '0;
  logic [31:0]     base_i = '0, index_i = '0, win_lo_i = '0, win_hi_i = '0;
  logic            wr_ready_i = 1'b0;
  logic            busy_o, done_o, fault_o, wr_valid_o;
  logic [LW-1:0]   fault_lane_o;
  logic [31:0]     wr_addr_o, wr_data_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] mem [256];
  logic [31:0] refm [256];

  always #10 clk = ~clk;

  vst_unit #(.VLEN(VLEN)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vec_i(vec_i), .pred_i(pred_i),
    .base_i(base_i), .index_i(index_i), .win_lo_i(win_lo_i), .win_hi_i(win_hi_i),
    .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .fault_lane_o(fault_lane_o),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_word(input int ci, input int k);
    return {8'hA0 + 8'(ci), 8'(k), 16'h5A00 ^ 16'(k * 37)};
  endfunction

  task automatic run_case(input int ci, input logic [72:0] e, input bit poke);
    logic [31:0] start_a, a;
    logic [15:0] m;
    bit exp_fault;
    int exp_lane, nexp, beats, it, last_it, bad_words;
    int exp_k [LANES];
    bit got_done;
    m = e[48:33];
    start_a = 32'(e[72:57]) + 32'(e[56:49]) * 4;
    exp_fault = 1'b0; exp_lane = 0; nexp = 0;
    for (int k = 0; k < LANES; k++) begin
      a = start_a + 32'(4 * k);
      if (m[k] && !(a >= 32'(e[31:16]) && a < 32'(e[15:0])) && !exp_fault) begin
        exp_fault = 1'b1; exp_lane = k;
      end
      if (m[k]) begin exp_k[nexp] = k; nexp++; end
    end
    if (exp_fault) nexp = 0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'hF000_0000 | 32'(i);
      refm[i] = mem[i];
    end
    for (int k = 0; k < nexp; k++) refm[(start_a[9:2] + 8'(exp_k[k]))] = lane_word(ci, exp_k[k]);

    @(negedge clk);
    for (int k = 0; k < LANES; k++) begin
      vec_i[32*k +: 32] = lane_word(ci, k);
      pred_i[4*k]   = m[k];
      pred_i[4*k+1] = e[32];
      pred_i[4*k+2] = e[32] & ~m[k];
      pred_i[4*k+3] = e[32] & k[0];
    end
    base_i = 32'(e[72:57]); index_i = 32'(e[56:49]);
    win_lo_i = 32'(e[31:16]); win_hi_i = 32'(e[15:0]);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R7", "busy after start", busy_o, 1);
    check(fault_o === 1'b0, "R11", "fault cleared by start", fault_o, 0);
    beats = 0; it = 0; last_it = -1; got_done = 1'b0;
    while (!got_done && it < 400) begin
      if (poke && it == 2) begin start_i = 1'b1; base_i = 32'h0000_0300; end
      else start_i = 1'b0;
      wr_ready_i = ((it % 3) != 1);
      #1;
      if (done_o) begin
        got_done = 1'b1;
        check(beats == nexp, "R3", "beat count", beats, nexp);
        check(fault_o === exp_fault, "R5 R6", "fault flag", fault_o, exp_fault);
        if (exp_fault) check(int'(fault_lane_o) == exp_lane, "R6", "fault lane", fault_lane_o, exp_lane);
        if (nexp == 0) check(it == 1, "R7 R8", "done delay without beats", it, 1);
        else check(it == last_it + 1, "R7", "done after last beat", it, last_it + 1);
      end else if (wr_valid_o && wr_ready_i) begin
        if (beats < nexp) begin
          a = start_a + 32'(4 * exp_k[beats]);
          check(wr_addr_o == a, poke ? "R1 R9" : "R1 R2", "beat address", wr_addr_o, a);
          check(wr_data_o == lane_word(ci, exp_k[beats]), "R1", "beat data",
                wr_data_o, lane_word(ci, exp_k[beats]));
        end else check(1'b0, "R3 R6", "unexpected beat", wr_addr_o, 0);
        mem[wr_addr_o[9:2]] = wr_data_o;
        beats++; last_it = it;
      end
      @(negedge clk);
      it++;
    end
    start_i = 1'b0; wr_ready_i = 1'b0;
    check(got_done, "R7", "watchdog waiting for done", it, 0);
    check(done_o === 1'b0 && busy_o === 1'b0, "R7", "done single pulse / idle",
          {done_o, busy_o}, 0);
    bad_words = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) bad_words++;
    check(bad_words == 0, "R4", "memory words differing from reference", bad_words, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy_o, done_o, wr_valid_o, fault_o} == 4'b0, "R10", "outputs in reset",
          {busy_o, done_o, wr_valid_o, fault_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy_o, done_o, wr_valid_o, fault_o} == 4'b0, "R10", "outputs after reset",
          {busy_o, done_o, wr_valid_o, fault_o}, 0);

    for (int ci = 0; ci < NCASE; ci++) run_case(ci, TBL[ci], ci == 0);

    // R11: fault state holds while idle, then an empty store clears it (R8)
    run_case(10, TBL[5], 1'b0);
    repeat (5) @(negedge clk);
    check(fault_o === 1'b1, "R11", "fault held while idle", fault_o, 1);
    check(int'(fault_lane_o) == 3, "R11", "fault lane held", fault_lane_o, 3);
    run_case(11, TBL[6], 1'b0);
    check(fault_o === 1'b0, "R8", "no fault after empty store", fault_o, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule